// File: doc/BRIEF.md
# Configuration Capability Search Engine

The block looks up one capability in a function's configuration space. Given a capability ID and a choice between the 256-byte standard list and the 4 KB extended list, it starts at the list head and follows the chain one entry at a time. It never assumes an entry sits at a fixed place. Every search starts again from the head.

Reads go through a plain synchronous port. The block drives a dword address together with a read strobe, and the data word returns one cycle later. A search begins with a one-cycle `start_i`. While it runs, `busy_o` is high. It ends with a one-cycle `done_o` that carries these results:
- a found or not-found result;
- an error flag for a list that ran too long;
- the dword index of the matching entry;
- for extended entries, the 4-bit version.

Malformed lists cannot hang the block. Pointers are aligned to dwords, standard pointers that point into the header end the list, and a per-list hop budget stops any loop.

Top module: `cap_walker`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `rd_en_o` are low.
- R2: When `start_i` is seen with the block idle, `busy_o` is high in the next cycle. The search ends with `done_o` high for exactly one cycle, with `busy_o` low in that cycle. A `start_i` seen while busy is ignored and does not change the result.
- R3: A standard search first reads dword 1. If bit 20 of that word (the capability-present bit of the status half) is 0, the search reports not-found after that single read.
- R4: The standard list head is byte 0 of dword 13 (byte offset 34h). Its two low bits are masked off. A head below 40h means the list is empty.
- R5: A standard entry holds its ID in bits 7:0 and its next byte pointer in bits 15:8. It matches only if the target's bits 15:8 are zero and its bits 7:0 equal the ID.
- R6: A standard next pointer below 40h, after masking, ends the list with not-found.
- R7: An extended search starts at dword 64 (byte 100h). An all-zero word there means the list is empty, and the result is not-found.
- R8: An extended entry holds a 16-bit ID in bits 15:0, the version in bits 19:16 and a 12-bit next byte pointer in bits 31:20. The low two bits of that pointer are masked, and a zero pointer ends the list.
- R9: On a match, the result is found with the matching entry's dword index. The version is reported for extended entries and is zero for standard ones.
- R10: If the Nth examined entry does not match and still has a next pointer, the result is error with found low. N is `STD_HOPS` for the standard list (default 64) and `EXT_HOPS` for the extended list (default 1024). A match on the Nth entry is still reported as found.
- R11: Reads happen only while busy, never in two consecutive cycles, and a standard search never addresses dword 64 or above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search (sampled when idle) |
| ext_sel_i | input | 1 | 1 selects the extended list, 0 the standard list |
| target_id_i | input | 16 | Capability ID to find |
| rd_en_o | output | 1 | Read strobe to configuration storage |
| rd_addr_o | output | 10 | Dword address of the read |
| rd_data_i | input | 32 | Read data, valid the cycle after the strobe |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | Target located (valid with done) |
| error_o | output | 1 | Hop budget exhausted (valid with done) |
| match_dw_o | output | 10 | Dword index of the matching entry |
| version_o | output | 4 | Version of the matching extended entry |

## Verification
A match and the end of the hop budget can occur on the same entry. The bench provokes this with the hop limits reduced to 8 and 16 and a chain of nine standard entries. Searching for the eighth entry's ID must give found with no error. Searching for an absent ID on the same chain must give error. Cutting the eighth entry's pointer to zero must turn that same search into a clean not-found without error. This separates the three outcomes that can compete in the final evaluation cycle.

// File: rtl/cap_walk_pkg.sv
package cap_walk_pkg;

    localparam int CFG_BYTES      = 4096;
    localparam int DW_AW          = $clog2(CFG_BYTES / 4);
    localparam int STATUS_DW      = 1;
    localparam int STATUS_CAP_BIT = 20;
    localparam int HEAD_DW        = 13;
    localparam int STD_FLOOR_DW   = 16;
    localparam int STD_SPACE_DW   = 64;
    localparam int EXT_HEAD_DW    = 64;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        PH_STATUS,
        PH_HEAD,
        PH_ENTRY
    } walk_phase_e;

    typedef struct packed {
        logic             empty;
        logic             hit;
        logic             last;
        logic [3:0]       ver;
        logic [DW_AW-1:0] next_dw;
    } entry_view_t;

    // Byte pointer of a standard list to a dword index; low bits dropped.
    function automatic logic [DW_AW-1:0] std_ptr_dw(input logic [7:0] ptr);
        return DW_AW'(ptr[7:2]);
    endfunction

    // A standard pointer landing inside the header (below 40h) ends the list.
    function automatic logic std_ptr_ends(input logic [7:0] ptr);
        return ptr[7:6] == 2'b00;
    endfunction

endpackage

// File: rtl/cw_entry_decode.sv
module cw_entry_decode
    import cap_walk_pkg::*;
(
    input  logic        ext_i,
    input  logic        first_i,
    input  logic [31:0] word_i,
    input  logic [15:0] target_i,
    output entry_view_t view_o
);

    always_comb begin
        view_o = '0;
        if (ext_i) begin
            view_o.empty   = first_i && (word_i == 32'h0);
            view_o.hit     = !view_o.empty && (word_i[15:0] == target_i);
            view_o.ver     = word_i[19:16];
            view_o.next_dw = word_i[31:22];
            view_o.last    = (word_i[31:22] == '0);
        end else begin
            view_o.empty   = 1'b0;
            view_o.hit     = (target_i[15:8] == 8'h0) && (word_i[7:0] == target_i[7:0]);
            view_o.ver     = 4'h0;
            view_o.next_dw = std_ptr_dw(word_i[15:8]);
            view_o.last    = std_ptr_ends(word_i[15:8]);
        end
    end

endmodule

// File: rtl/cw_hop_guard.sv
module cw_hop_guard #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             last_hop_o
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            count_q <= '0;
        end else if (step_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign last_hop_o = (count_q == (limit_i - 1'b1));

endmodule

// File: rtl/cap_walker.sv
module cap_walker
    import cap_walk_pkg::*;
#(
    parameter int STD_HOPS = 64,
    parameter int EXT_HOPS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              ext_sel_i,
    input  logic [15:0]       target_id_i,
    output logic              rd_en_o,
    output logic [DW_AW-1:0]  rd_addr_o,
    input  logic [31:0]       rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              found_o,
    output logic              error_o,
    output logic [DW_AW-1:0]  match_dw_o,
    output logic [3:0]        version_o
);

    localparam int MAX_HOPS = (STD_HOPS > EXT_HOPS) ? STD_HOPS : EXT_HOPS;
    localparam int CNT_W    = $clog2(MAX_HOPS + 1);

    walk_state_e      state_q;
    walk_phase_e      phase_q;
    logic             ext_q;
    logic [15:0]      target_q;
    logic [DW_AW-1:0] addr_q;
    logic             found_q;
    logic             err_q;
    logic [DW_AW-1:0] match_q;
    logic [3:0]       ver_q;

    entry_view_t      view;
    logic             first_entry;
    logic             last_hop;
    logic             hop_clear;
    logic             hop_step;
    logic [CNT_W-1:0] hop_limit;
    logic             in_entry_eval;

    assign first_entry   = ext_q && (addr_q == DW_AW'(EXT_HEAD_DW));
    assign hop_limit     = ext_q ? CNT_W'(EXT_HOPS) : CNT_W'(STD_HOPS);
    assign hop_clear     = (state_q == ST_IDLE) && start_i;
    assign in_entry_eval = (state_q == ST_EVAL) && (phase_q == PH_ENTRY);
    assign hop_step      = in_entry_eval && !view.empty && !view.hit
                           && !view.last && !last_hop;

    cw_entry_decode u_decode (
        .ext_i    (ext_q),
        .first_i  (first_entry),
        .word_i   (rd_data_i),
        .target_i (target_q),
        .view_o   (view)
    );

    cw_hop_guard #(
        .CNT_W (CNT_W)
    ) u_guard (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (hop_clear),
        .step_i     (hop_step),
        .limit_i    (hop_limit),
        .last_hop_o (last_hop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            phase_q  <= PH_STATUS;
            ext_q    <= 1'b0;
            target_q <= '0;
            addr_q   <= '0;
            found_q  <= 1'b0;
            err_q    <= 1'b0;
            match_q  <= '0;
            ver_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        ext_q    <= ext_sel_i;
                        target_q <= target_id_i;
                        found_q  <= 1'b0;
                        err_q    <= 1'b0;
                        match_q  <= '0;
                        ver_q    <= '0;
                        state_q  <= ST_READ;
                        if (ext_sel_i) begin
                            phase_q <= PH_ENTRY;
                            addr_q  <= DW_AW'(EXT_HEAD_DW);
                        end else begin
                            phase_q <= PH_STATUS;
                            addr_q  <= DW_AW'(STATUS_DW);
                        end
                    end
                end
                ST_READ: begin
                    state_q <= ST_EVAL;
                end
                ST_EVAL: begin
                    unique case (phase_q)
                        PH_STATUS: begin
                            if (rd_data_i[STATUS_CAP_BIT]) begin
                                phase_q <= PH_HEAD;
                                addr_q  <= DW_AW'(HEAD_DW);
                                state_q <= ST_READ;
                            end else begin
                                state_q <= ST_DONE;
                            end
                        end
                        PH_HEAD: begin
                            if (std_ptr_ends(rd_data_i[7:0])) begin
                                state_q <= ST_DONE;
                            end else begin
                                phase_q <= PH_ENTRY;
                                addr_q  <= std_ptr_dw(rd_data_i[7:0]);
                                state_q <= ST_READ;
                            end
                        end
                        default: begin
                            if (view.empty) begin
                                state_q <= ST_DONE;
                            end else if (view.hit) begin
                                found_q <= 1'b1;
                                match_q <= addr_q;
                                ver_q   <= view.ver;
                                state_q <= ST_DONE;
                            end else if (view.last) begin
                                state_q <= ST_DONE;
                            end else if (last_hop) begin
                                err_q   <= 1'b1;
                                state_q <= ST_DONE;
                            end else begin
                                addr_q  <= view.next_dw;
                                state_q <= ST_READ;
                            end
                        end
                    endcase
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign rd_en_o    = (state_q == ST_READ);
    assign rd_addr_o  = addr_q;
    assign busy_o     = (state_q == ST_READ) || (state_q == ST_EVAL);
    assign done_o     = (state_q == ST_DONE);
    assign found_o    = found_q;
    assign error_o    = err_q;
    assign match_dw_o = match_q;
    assign version_o  = ver_q;

endmodule

// File: rtl/cw_walk_chk.sv
module cw_walk_chk
    import cap_walk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             found,
    input logic             error,
    input logic             rd_en,
    input logic [DW_AW-1:0] rd_addr,
    input logic             ext_mode,
    input logic [3:0]       ver
);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> busy);

    // R10
    found_error_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !(found && error));

    // R11
    read_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> busy);

    // R11
    read_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);

    // R11
    std_range_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !ext_mode) |-> (rd_addr < DW_AW'(STD_SPACE_DW)));

    // R9
    std_version_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !ext_mode) |-> (ver == 4'h0));

endmodule

bind cap_walker cw_walk_chk u_walk_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start_i),
    .busy     (busy_o),
    .done     (done_o),
    .found    (found_o),
    .error    (error_o),
    .rd_en    (rd_en_o),
    .rd_addr  (rd_addr_o),
    .ext_mode (ext_q),
    .ver      (version_o)
);

// File: tb/test_cap_walker.sv
module test_cap_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ext_sel = 1'b0;
    logic [15:0] target = 16'h0;
    logic        rd_en;
    logic [9:0]  rd_addr;
    logic [31:0] rd_data = 32'h0;
    logic        busy, done, found, error;
    logic [9:0]  match_dw;
    logic [3:0]  version;

    logic [31:0] mem [0:1023];
    int checks = 0;
    int errors = 0;
    int reads = 0;
    int std_oob = 0;
    logic cur_ext = 1'b0;

    logic        r_found, r_error;
    logic [9:0]  r_dw;
    logic [3:0]  r_ver;

    always #2.5 clk = ~clk;

    cap_walker #(
        .STD_HOPS (8),
        .EXT_HOPS (16)
    ) i_cap_walker (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .ext_sel_i   (ext_sel),
        .target_id_i (target),
        .rd_en_o     (rd_en),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data),
        .busy_o      (busy),
        .done_o      (done),
        .found_o     (found),
        .error_o     (error),
        .match_dw_o  (match_dw),
        .version_o   (version)
    );

    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
            reads   <= reads + 1;
            if (!cur_ext && rd_addr >= 10'd64) std_oob <= std_oob + 1;
        end
    end

    function automatic logic [31:0] std_ent(input logic [7:0] id, input logic [7:0] nxt);
        return {16'h0, nxt, id};
    endfunction

    function automatic logic [31:0] ext_ent(input logic [15:0] id, input logic [3:0] v,
                                            input logic [11:0] nxt);
        return {nxt, v, id};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    endtask

    task automatic run(input logic ext, input logic [15:0] id, input bit poke);
        int n;
        @(negedge clk);
        cur_ext = ext;
        reads   = 0;
        start   = 1'b1;
        ext_sel = ext;
        target  = id;
        @(negedge clk);
        start = 1'b0;
        check("R2", "busy after start", busy, 1'b1);
        n = 0;
        while (!done && n < 5000) begin
            if (poke && n == 1) begin
                start   = 1'b1;
                ext_sel = !ext;
                target  = 16'h0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        if (n >= 5000) check("R2", "done timeout", 1'b0, 1'b1);
        check("R2", "busy low with done", busy, 1'b0);
        r_found = found;
        r_error = error;
        r_dw    = match_dw;
        r_ver   = version;
        @(negedge clk);
        check("R2", "done one cycle", done, 1'b0);
    endtask

    task automatic t_reset();
        check("R1", "busy", busy, 1'b0);
        check("R1", "done", done, 1'b0);
        check("R1", "rd_en", rd_en, 1'b0);
    endtask

    task automatic t_no_cap_bit();
        clear_mem();
        mem[1]  = 32'h0000_0000;
        mem[13] = 32'h40;
        mem[16] = std_ent(8'h05, 8'h00);
        run(1'b0, 16'h0005, 1'b0);
        check("R3", "found", r_found, 1'b0);
        check("R3", "single read", reads, 1);
    endtask

    task automatic t_std_walk();
        clear_mem();
        mem[1]  = 32'h1 << 20;
        mem[13] = 32'h43;
        mem[16] = std_ent(8'h01, 8'h50);
        mem[20] = std_ent(8'h05, 8'h63);
        mem[24] = std_ent(8'h10, 8'h00);
        run(1'b0, 16'h0005, 1'b0);
        check("R4", "found mid", r_found, 1'b1);
        check("R9", "dw mid", r_dw, 10'd20);
        check("R9", "std version", r_ver, 4'h0);
        run(1'b0, 16'h0010, 1'b1);
        check("R5", "found tail", r_found, 1'b1);
        check("R2", "dw tail despite restart", r_dw, 10'd24);
        run(1'b0, 16'h0022, 1'b0);
        check("R6", "absent", r_found, 1'b0);
        check("R6", "no error", r_error, 1'b0);
        run(1'b0, 16'h0105, 1'b0);
        check("R5", "upper target byte", r_found, 1'b0);
        mem[13] = 32'h3C;
        run(1'b0, 16'h0001, 1'b0);
        check("R4", "head below 40h", r_found, 1'b0);
        check("R4", "two reads", reads, 2);
    endtask

    task automatic t_ext_walk();
        clear_mem();
        mem[64]  = ext_ent(16'h0001, 4'h1, 12'h148);
        mem[82]  = ext_ent(16'h000B, 4'h2, 12'h203);
        mem[128] = ext_ent(16'h0019, 4'h3, 12'h000);
        run(1'b1, 16'h0019, 1'b0);
        check("R8", "found last", r_found, 1'b1);
        check("R9", "dw last", r_dw, 10'd128);
        check("R8", "version last", r_ver, 4'h3);
        run(1'b1, 16'h000B, 1'b0);
        check("R9", "dw mid", r_dw, 10'd82);
        check("R8", "version mid", r_ver, 4'h2);
        run(1'b1, 16'h7777, 1'b0);
        check("R8", "absent", r_found, 1'b0);
        check("R8", "absent no error", r_error, 1'b0);
        mem[64] = 32'h0;
        run(1'b1, 16'h0000, 1'b0);
        check("R7", "empty list", r_found, 1'b0);
        check("R7", "single read", reads, 1);
    endtask

    task automatic t_hop_limit();
        clear_mem();
        mem[1]  = 32'h1 << 20;
        mem[13] = 32'h40;
        for (int i = 0; i < 9; i++) begin
            mem[16 + i] = std_ent(8'h80 + 8'(i), 8'((16 + i + 1) * 4));
        end
        run(1'b0, 16'h00FF, 1'b0);
        check("R10", "error on long chain", r_error, 1'b1);
        check("R10", "found low", r_found, 1'b0);
        run(1'b0, 16'h0087, 1'b0);
        check("R10", "match on last hop", r_found, 1'b1);
        check("R10", "no error on match", r_error, 1'b0);
        check("R9", "dw last hop", r_dw, 10'd23);
        mem[23] = std_ent(8'h87, 8'h00);
        run(1'b0, 16'h00FF, 1'b0);
        check("R6", "end on last hop", r_error, 1'b0);
        mem[16] = std_ent(8'h80, 8'h40);
        run(1'b0, 16'h00FF, 1'b0);
        check("R10", "std self loop", r_error, 1'b1);
        mem[64] = ext_ent(16'h0001, 4'h1, 12'h100);
        run(1'b1, 16'h0002, 1'b0);
        check("R10", "ext self loop", r_error, 1'b1);
        check("R11", "std range", std_oob, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_cap_bit();
        t_std_walk();
        t_ext_walk();
        t_hop_limit();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule